// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a memory burst. A column command loads a start column, a length code and an order select (sequential or interleaved). From the next cycle on, the block presents one column per beat and moves to the next beat on each clock where `advance` is high. It also drives a valid flag and a flag that marks the final beat. Command timing and read-latency data alignment are handled outside this block.

Fixed lengths of 1, 2, 4 and 8 beats keep every address inside the aligned block whose size equals the length. The low bits wrap and the upper bits never change. Sequential order adds the beat index to the start's low bits. Interleaved order XORs the start's low bits with the beat index. A full-page burst walks the whole column space and wraps at its top. It has no final beat of its own and runs until `terminate` ends it. If the command asks for an illegal combination, the burst is refused and a one-cycle error flag is raised.

The control is a three-state machine:
- `ST_IDLE`: no burst is running.
- `ST_BURST`: a fixed-length burst is running.
- `ST_FULL`: a full-page burst is running.

The machine makes these transitions:
- start_ok: any state to `ST_BURST` or `ST_FULL` on an accepted command.
- start_bad: any state to `ST_IDLE` with the error flag set, on a refused command.
- stop: `ST_BURST` or `ST_FULL` to `ST_IDLE` on `terminate`.
- finish: `ST_BURST` to `ST_IDLE` when the last beat is advanced.
- step: stay in the current burst state and add one to the beat index on `advance`.
- hold: keep everything when no input is active.

Top module: `burst_col_gen`

## Requirements
- R1: During and directly after reset, `valid`, `last` and `err` are 0.
- R2: In the cycle after an accepted `start`, `valid` is 1 and `col` equals the `start_col` given with it.
- R3: Length code `len_code` values are 0→1 beat, 1→2, 2→4, 3→8 and 7→full page. Codes 4, 5 and 6 are reserved.
- R4: In a fixed-length burst, the bits of `col` above log2(length) stay equal to those of the start column for every beat.
- R5: With `ilv`=0, beat k has low bits equal to (start + k) mod length.
- R6: With `ilv`=1, beat k has low bits equal to start XOR k. For length 8 and start 2, the columns are 2,3,0,1,6,7,4,5.
- R7: `last` is 1 exactly on beat length−1 of a fixed-length burst. For length 1 this is the first beat. Advancing past that beat makes `valid` 0 in the next cycle, unless a new `start` is given.
- R8: While a burst runs and `advance`, `start` and `terminate` are all 0, `col`, `valid` and `last` hold their values.
- R9: A full-page burst (code 7, `ilv`=0) steps `col` by one, modulo 2^COL_W, on each advance. It never raises `last`, and it continues until terminated.
- R10: `terminate` without `start` makes `valid` 0 in the next cycle.
- R11: A `start` with code 7 and `ilv`=1, or with a reserved code, is refused. In the next cycle `err` is 1 and `valid` is 0, and `err` returns to 0 one cycle later.
- R12: `start` has priority over `terminate` and `advance`. A `start` given on a running burst's last beat, or together with `terminate`, begins the new burst in the next cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Column command: load a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| advance | input | 1 | Move to the next beat |
| terminate | input | 1 | End the running burst |
| col | output | COL_W | Column for the current beat |
| valid | output | 1 | A beat is being presented |
| last | output | 1 | Current beat is the final one |
| err | output | 1 | Previous command was refused |

## Verification
The case that needs the most care is a new column command arriving in the same cycle as a burst-ending event. That event can be the advance past the last beat or a terminate. The bench provokes both collisions on purpose. It raises `start` with new parameters on a last beat while `advance` is high, and again together with `terminate` during a full-page burst. It then checks that the next cycle shows beat 0 of the new burst with `valid` still 1. Random bursts with random stalls cover the ordering rules around these cases.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FULL  = 2'd2
    } bst_state_e;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

endpackage

// File: rtl/len_decode.sv
module len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code,
    output logic [COL_W-1:0] mask,
    output logic             is_full,
    output logic             code_ok
);
    import burst_col_pkg::*;

    always_comb begin
        mask    = '0;
        is_full = 1'b0;
        code_ok = 1'b1;
        case (code)
            LEN_1, LEN_2, LEN_4, LEN_8: mask = (COL_W'(1) << code) - COL_W'(1);
            LEN_PAGE: begin
                mask    = '1;
                is_full = 1'b1;
            end
            default: code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/col_calc.sv
module col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = base + beat;
        low_ilv = base ^ beat;
        col     = (base & ~mask) | ((ilv ? low_ilv : low_seq) & mask);
    end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv_in,
    input  logic             advance,
    input  logic             terminate,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q,
    output logic             valid,
    output logic             last,
    output logic             err,
    output logic             full_mode
);
    import burst_col_pkg::*;

    bst_state_e       state_q, state_d;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full, dec_ok, cmd_ok;
    logic             err_q;

    len_decode #(.COL_W(COL_W)) i_dec (
        .code    (len_code),
        .mask    (dec_mask),
        .is_full (dec_full),
        .code_ok (dec_ok)
    );

    assign cmd_ok = dec_ok && !(dec_full && ilv_in);

    always_comb begin
        state_d = state_q;
        if (start) begin
            if (!cmd_ok)       state_d = ST_IDLE;
            else if (dec_full) state_d = ST_FULL;
            else               state_d = ST_BURST;
        end else if (terminate) begin
            state_d = ST_IDLE;
        end else if (advance) begin
            unique case (state_q)
                ST_BURST: if (beat_q == mask_q) state_d = ST_IDLE;
                ST_FULL:  state_d = ST_FULL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= start && !cmd_ok;
            if (start && cmd_ok) begin
                base_q <= start_col;
                beat_q <= '0;
                mask_q <= dec_mask;
                ilv_q  <= ilv_in;
            end else if (!start && !terminate && advance && state_q != ST_IDLE) begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    always_comb begin
        valid     = (state_q != ST_IDLE);
        last      = (state_q == ST_BURST) && (beat_q == mask_q);
        full_mode = (state_q == ST_FULL);
        err       = err_q;
    end

    a_r9_full_never_last: assert property (@(posedge clk) disable iff (!rst_n)
        full_mode |-> !last);
    a_r10_terminate_stops: assert property (@(posedge clk) disable iff (!rst_n)
        valid && terminate && !start |=> !valid);
    a_r11_err_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !valid);
    a_r7_finish_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last && advance && !start && !terminate |=> !valid);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv,
    input  logic             advance,
    input  logic             terminate,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last,
    output logic             err
);
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             ilv_q, full_mode;

    burst_ctrl #(.COL_W(COL_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .len_code  (len_code),
        .ilv_in    (ilv),
        .advance   (advance),
        .terminate (terminate),
        .base_q    (base_q),
        .beat_q    (beat_q),
        .mask_q    (mask_q),
        .ilv_q     (ilv_q),
        .valid     (valid),
        .last      (last),
        .err       (err),
        .full_mode (full_mode)
    );

    col_calc #(.COL_W(COL_W)) i_calc (
        .base (base_q),
        .beat (beat_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col)
    );

    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        start && !(len_code inside {3'd4, 3'd5, 3'd6}) && !(len_code == 3'd7 && ilv)
        |=> valid && col == $past(start_col));
    a_r4_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !start |=> !valid || ((col & ~mask_q) == ($past(col) & ~$past(mask_q))));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !advance && !start && !terminate |=> valid && $stable(col) && $stable(last));
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0, ilv = 1'b0, advance = 1'b0, terminate = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = '0;
    logic [COL_W-1:0] col;
    logic             valid, last, err;
    int               n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv(ilv), .advance(advance), .terminate(terminate),
        .col(col), .valid(valid), .last(last), .err(err)
    );

    function automatic int blen(input logic [2:0] c);
        return (c == 3'd7) ? (1 << COL_W) : (1 << c);
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic [2:0] c, input logic i, input int k);
        logic [COL_W-1:0] m, lo;
        m  = COL_W'(blen(c) - 1);
        lo = i ? (s ^ COL_W'(k)) : (s + COL_W'(k));
        return (s & ~m) | (lo & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [COL_W-1:0] s, input logic [2:0] c, input logic i);
        start = 1'b1; start_col = s; len_code = c; ilv = i;
        advance = 1'b0; terminate = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_beat(input logic [COL_W-1:0] s, input logic [2:0] c,
            input logic i, input int k, input string req);
        chk(valid === 1'b1, {req, " valid"}, int'(valid), 1);
        chk(col === exp_col(s, c, i, k), {req, " col"}, int'(col), int'(exp_col(s, c, i, k)));
        chk(last === (c != 3'd7 && k == blen(c) - 1), {req, " last"}, int'(last),
            int'(c != 3'd7 && k == blen(c) - 1));
    endtask

    task automatic step(input bit stall);
        if (stall) begin
            advance = 1'b0;
            @(negedge clk);
        end
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic run_fixed(input logic [COL_W-1:0] s, input logic [2:0] c,
            input logic i, input bit rnd_stall, input string req);
        issue(s, c, i);
        for (int k = 0; k < blen(c); k++) begin
            check_beat(s, c, i, k, req);
            if (rnd_stall && ($urandom % 4 == 0)) begin
                advance = 1'b0;
                @(negedge clk);
                check_beat(s, c, i, k, "R8 stall");
            end
            step(1'b0);
        end
        chk(valid === 1'b0, "R7 valid after last", int'(valid), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(valid === 1'b0 && last === 1'b0 && err === 1'b0, "R1 reset outputs",
            int'({valid, last, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid === 1'b0 && err === 1'b0, "R1 after reset", int'({valid, err}), 0);

        // R6 example: interleaved length 8 from 2 -> 2,3,0,1,6,7,4,5
        run_fixed(8'd2, 3'd3, 1'b1, 1'b0, "R6 ilv8 start2");
        run_fixed(8'h4D, 3'd3, 1'b0, 1'b0, "R5 seq8 wrap R4");
        run_fixed(8'h93, 3'd2, 1'b1, 1'b0, "R6 ilv4");
        run_fixed(8'h37, 3'd1, 1'b0, 1'b0, "R3 len2");
        run_fixed(8'hA5, 3'd0, 1'b0, 1'b0, "R7 len1");

        for (int n = 0; n < 40; n++)
            run_fixed(COL_W'($urandom), 3'($urandom % 4), 1'($urandom), 1'b1, "R5 R6 random");

        // R9 full page: wraps, no last, until terminate
        issue(8'hF0, 3'd7, 1'b0);
        for (int k = 0; k < 300; k++) begin
            if (k % 50 == 0) check_beat(8'hF0, 3'd7, 1'b0, k, "R9 full page");
            else chk(col === exp_col(8'hF0, 3'd7, 1'b0, k) && last === 1'b0,
                     "R9 full page col", int'(col), int'(exp_col(8'hF0, 3'd7, 1'b0, k)));
            step(1'b0);
        end
        terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        chk(valid === 1'b0, "R10 terminate", int'(valid), 0);

        // R11 refused commands
        issue(8'h10, 3'd7, 1'b1);
        chk(err === 1'b1 && valid === 1'b0, "R11 ilv full page", int'({err, valid}), 2);
        @(negedge clk);
        chk(err === 1'b0, "R11 err clears", int'(err), 0);
        issue(8'h10, 3'd5, 1'b0);
        chk(err === 1'b1 && valid === 1'b0, "R11 reserved code R3", int'({err, valid}), 2);

        // R12 start on the last beat with advance
        issue(8'h21, 3'd1, 1'b0);
        check_beat(8'h21, 3'd1, 1'b0, 0, "R12 pre");
        step(1'b0);
        check_beat(8'h21, 3'd1, 1'b0, 1, "R12 pre last");
        start = 1'b1; advance = 1'b1; start_col = 8'h66; len_code = 3'd2; ilv = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        check_beat(8'h66, 3'd2, 1'b1, 0, "R12 start on last");

        // R12 start together with terminate during full page
        issue(8'h05, 3'd7, 1'b0);
        step(1'b0);
        start = 1'b1; terminate = 1'b1; start_col = 8'hC3; len_code = 3'd3; ilv = 1'b0;
        @(negedge clk);
        start = 1'b0; terminate = 1'b0;
        check_beat(8'hC3, 3'd3, 1'b0, 0, "R12 start with terminate");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule